// File: doc/BRIEF.md
# Selectable-Tap Noise Shift-Register Generator

This block produces a pseudorandom bit stream for a noise voice. A 15-bit shift register advances once per step period. The period is set by an 11-bit pitch word: a larger word gives a shorter period. On each step the register moves up by one place. A new bit enters at the bottom, formed from the inverted exclusive-OR of register bit 7 and a second bit. A 3-bit selector picks that second bit from a fixed set of eight positions, and each choice gives a different sequence length and a different sound colour.

The voice runs while its enable input is high and freezes while it is low. Each time the enable goes high, the register starts again from all zeros and a fresh step period begins. Because the feedback is inverted, the all-zero start state is not a lock-up state. The generator exposes its whole register so that a downstream mixer can use either the register or just the low bit.

Top module: `noise_lfsr_gen`

## Requirements
- R1: While reset is asserted and after it is released, with the enable low, the register output is all zeros and the noise bit is 0.
- R2: On the first clock edge at which the enable is seen high after being low, the register is cleared to zero and a new step period starts, whatever its previous contents.
- R3: While enabled, the register steps once every PERIOD_MUL × (2048 − pitch) clock cycles, with PERIOD_MUL defaulting to 40. The first step comes that many cycles after the restart edge, and this includes the extreme pitch values 0 and 2047.
- R4: A step moves bits 13..0 into bits 14..1 and drops the old bit 14. Bit 0 receives NOT(bit 7 XOR tapped bit).
- R5: Tap select values 0 to 7 pick register bit 14, 10, 13, 4, 8, 6, 9 and 11 respectively.
- R6: While the enable is low, the register and the step timing do not change.
- R7: The pitch word is sampled only when a step period is reloaded. A pitch change in the middle of a period affects only the following period.
- R8: The noise bit always equals register bit 0.
- R9: The tap select is applied at the step edge, so a change between steps takes effect at the next step.
- R10: The first step from the all-zero state yields the value 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Voice enable; a rising level restarts the generator |
| freq | input | 11 | Pitch word; the period is PERIOD_MUL × (2048 − freq) cycles |
| tap_sel | input | 3 | Selects the second feedback bit |
| lfsr_state | output | 15 | Current shift-register contents |
| noise_bit | output | 1 | Noise output, register bit 0 |

## Verification
The bench builds the block with PERIOD_MUL set to 2 and the pitch width left at 11 bits. With these values even pitch 0 gives a period of 4096 cycles, so the slowest period, the fastest period of 2 cycles, and many steps for every tap select all fit in a short run. A behavioural reference model is compared with both outputs on every clock. Directed latency measurements check the restart, the reload-time pitch sampling and the first step out of zero.

// File: rtl/noise_lfsr_pkg.sv
package noise_lfsr_pkg;

  localparam int NOISE_W   = 15;
  localparam int FB_BIT    = 7;
  localparam int NUM_TAPS  = 8;
  localparam int TAP_SEL_W = $clog2(NUM_TAPS);

  // Register bit used as the second feedback input for each tap select value.
  function automatic int tap_pos(input int idx);
    case (idx)
      0:       return 14;
      1:       return 10;
      2:       return 13;
      3:       return 4;
      4:       return 8;
      5:       return 6;
      6:       return 9;
      default: return 11;
    endcase
  endfunction

endpackage

// File: rtl/noise_rst_sync.sv
module noise_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/noise_step_timer.sv
module noise_step_timer #(
  parameter int FREQ_W     = 11,
  parameter int PERIOD_MUL = 40,
  parameter int CNT_W      = 17
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] freq_i,
  output logic              step_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] span;
  logic [CNT_W-1:0] reload;

  // Period length minus one, computed from the pitch word at reload time.
  always_comb begin
    span   = CNT_W'(2 ** FREQ_W) - CNT_W'(freq_i);
    reload = (span * CNT_W'(PERIOD_MUL)) - CNT_W'(1);
  end

  always_comb begin
    cnt_d  = cnt_q;
    step_o = 1'b0;
    if (start_i) begin
      cnt_d = reload;
    end else if (en_i) begin
      if (cnt_q == '0) begin
        step_o = 1'b1;
        cnt_d  = reload;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R3
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (en_i && !start_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R6
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!en_i && !start_i) |=> $stable(cnt_q));

endmodule

// File: rtl/noise_tap_mux.sv
module noise_tap_mux
  import noise_lfsr_pkg::*;
#(
  parameter int W = NOISE_W
) (
  input  logic [W-1:0]         state_i,
  input  logic [TAP_SEL_W-1:0] sel_i,
  output logic                 tap_o
);

  logic [NUM_TAPS-1:0] cand;

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    assign cand[g] = state_i[tap_pos(g)];
  end

  assign tap_o = cand[sel_i];

endmodule

// File: rtl/noise_shift_reg.sv
module noise_shift_reg #(
  parameter int W      = 15,
  parameter int FB_POS = 7
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         step_i,
  input  logic         tap_i,
  output logic [W-1:0] state_o
);

  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic         fb;

  always_comb begin
    fb      = ~(state_q[FB_POS] ^ tap_i);
    state_d = state_q;
    if (start_i)     state_d = '0;
    else if (step_i) state_d = {state_q[W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) state_q <= '0;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R2
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    start_i |=> (state_q == '0));

  // R4
  shift_up_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (step_i && !start_i) |=> (state_q[W-1:1] == $past(state_q[W-2:0])));

  // R10
  zero_escape_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (step_i && !start_i && state_q == '0) |=> (state_q == W'(1)));

endmodule

// File: rtl/noise_lfsr_gen.sv
module noise_lfsr_gen
  import noise_lfsr_pkg::*;
#(
  parameter int FREQ_W     = 11,
  parameter int PERIOD_MUL = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [FREQ_W-1:0]    freq,
  input  logic [TAP_SEL_W-1:0] tap_sel,
  output logic [NOISE_W-1:0]   lfsr_state,
  output logic                 noise_bit
);

  localparam int CNT_W = $clog2(PERIOD_MUL * (2 ** FREQ_W) + 1);

  logic rst_sync_n;
  logic en_q;
  logic en_d;
  logic start;
  logic step;
  logic tap_bit;

  noise_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .arst_ni (rst_n),
    .rst_no  (rst_sync_n)
  );

  always_comb begin
    en_d  = en;
    start = en & ~en_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) en_q <= 1'b0;
    else             en_q <= en_d;
  end

  noise_step_timer #(
    .FREQ_W     (FREQ_W),
    .PERIOD_MUL (PERIOD_MUL),
    .CNT_W      (CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst_ni  (rst_sync_n),
    .en_i    (en),
    .start_i (start),
    .freq_i  (freq),
    .step_o  (step)
  );

  noise_tap_mux #(.W(NOISE_W)) u_tap (
    .state_i (lfsr_state),
    .sel_i   (tap_sel),
    .tap_o   (tap_bit)
  );

  noise_shift_reg #(.W(NOISE_W), .FB_POS(FB_BIT)) u_sreg (
    .clk     (clk),
    .rst_ni  (rst_sync_n),
    .start_i (start),
    .step_i  (step),
    .tap_i   (tap_bit),
    .state_o (lfsr_state)
  );

  assign noise_bit = lfsr_state[0];

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !en |=> $stable(lfsr_state));

  // R3
  no_step_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    step |-> (en && en_q));

endmodule

// File: tb/noise_lfsr_gen_tb.sv
module noise_lfsr_gen_tb;

  localparam int FW  = 11;
  localparam int MUL = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [FW-1:0] freq = '0;
  logic [2:0]    sel = '0;
  logic [14:0]   lfsr_state;
  logic          noise_bit;

  noise_lfsr_gen #(.FREQ_W(FW), .PERIOD_MUL(MUL)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .freq       (freq),
    .tap_sel    (sel),
    .lfsr_state (lfsr_state),
    .noise_bit  (noise_bit)
  );

  always #10 clk = ~clk;

  int    n_tests = 0;
  int    n_fail  = 0;
  int    cyc     = 0;
  bit    cmp_on  = 1'b0;
  bit    done    = 1'b0;
  string cur_req = "R1";

  int taps [8] = '{14, 10, 13, 4, 8, 6, 9, 11};

  function automatic int per(input logic [FW-1:0] f);
    return MUL * ((2 ** FW) - int'(f));
  endfunction

  // Behavioural reference
  logic [14:0] m_st;
  int          m_cnt;
  bit          m_en_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = '0; m_cnt = 0; m_en_prev = 1'b0;
    end else begin
      if (en && !m_en_prev) begin
        m_st  = '0;
        m_cnt = per(freq) - 1;
      end else if (en) begin
        if (m_cnt == 0) begin
          m_st  = {m_st[13:0], ~(m_st[7] ^ m_st[taps[sel]])};
          m_cnt = per(freq) - 1;
        end else begin
          m_cnt = m_cnt - 1;
        end
      end
      m_en_prev = en;
    end
  end

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp, input string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(cur_req, 32'(lfsr_state), 32'(m_st), "state vs model");
      chk("R8", 32'(noise_bit), 32'(lfsr_state[0]), "bit vs state[0]");
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic restart();
    en = 1'b0;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
  endtask

  task automatic measure(output int lat);
    logic [14:0] s0;
    s0  = lfsr_state;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (lfsr_state == s0 && lat < 10000);
  endtask

  initial begin
    int lat;
    int lat2;
    logic [14:0] snap;

    repeat (3) @(negedge clk);
    chk("R1", 32'(lfsr_state), 0, "state in reset");
    chk("R1", 32'(noise_bit), 0, "bit in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", 32'(lfsr_state), 0, "state after release");
    cmp_on = 1'b1;

    // R3 and R10: first step latency and value out of zero
    cur_req = "R3";
    freq = 11'd2040;
    restart();
    measure(lat);
    chk("R3", 32'(lat), 32'(per(11'd2040)), "first step latency");
    chk("R10", 32'(lfsr_state), 1, "first step from zero");

    // R4, R5, R9: every tap select, changed between steps
    for (int s = 0; s < 8; s++) begin
      cur_req = "R5";
      sel = 3'(s);
      repeat (120) @(negedge clk);
    end
    cur_req = "R9";
    for (int s = 7; s >= 0; s--) begin
      sel = 3'(s);
      repeat (7) @(negedge clk);
    end

    // R6: hold while disabled
    cur_req = "R6";
    en = 1'b0;
    snap = lfsr_state;
    freq = 11'd1000;
    sel  = 3'd3;
    repeat (60) @(negedge clk);
    chk("R6", 32'(lfsr_state), 32'(snap), "held while disabled");

    // R2: re-enable clears
    cur_req = "R2";
    freq = 11'd2046;
    en = 1'b1;
    @(negedge clk);
    chk("R2", 32'(lfsr_state), 0, "cleared on enable");

    // R7: pitch change mid-period
    cur_req = "R7";
    repeat (40) @(negedge clk);
    freq = 11'd2000;
    repeat (300) @(negedge clk);
    freq = 11'd2046;
    restart();
    freq = 11'd2030;
    measure(lat);
    measure(lat2);
    chk("R7", 32'(lat), 32'(per(11'd2046)), "period with old pitch");
    chk("R7", 32'(lat2), 32'(per(11'd2030)), "period with new pitch");

    // R3 boundaries: fastest and slowest pitch
    cur_req = "R3";
    freq = 11'd2047;
    restart();
    measure(lat);
    chk("R3", 32'(lat), 32'(per(11'd2047)), "latency at pitch 2047");
    repeat (50) @(negedge clk);
    freq = 11'd0;
    restart();
    measure(lat);
    chk("R3", 32'(lat), 32'(per(11'd0)), "latency at pitch 0");
    repeat (4200) @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule